// File: doc/BRIEF.md
# Multi-round Keccak permutation unit

The unit applies a selectable number of Keccak-p[1600] rounds to a 1600-bit state. The state is supplied as a 2048-bit group of thirty-two 64-bit elements. Twenty-five of these elements carry the state lanes. The remaining seven are spare elements that do not enter the permutation. A 5-bit immediate sets the round count: the unit runs the immediate plus one rounds, so 1 to 32 rounds are possible. The rounds used are always the last ones of the schedule and end at round index 23. A count of 24 therefore gives the full standard permutation.

Each clock cycle one complete round is computed: theta, rho, pi, chi and iota. The iota constants come from a table that is worked out at elaboration from the degree-8 LFSR. The table also covers the negative round indices that counts above 24 need. The result group has the same element layout as the input, and the controlling system writes it back in place of the operand. A tail select decides what the spare elements hold: their input values, or all ones.

Two alignment checks run alongside the computation. The low bits of the group count and of the starting element offset must both be zero, that is a multiple of 32. If either is not, an error flag is raised together with the result. The number of cycles depends only on the round count and never on the state data.

Top module: `keccak_rounds_unit`

## Requirements
- R1: With rounds_i = m, the unit applies n = m+1 rounds of Keccak-p[1600] with round indices 24-n through 23. Each iota constant comes from the degree-8 LFSR (x^8+x^6+x^5+x^4+1), and its exponent is taken modulo 255 for negative indices. With m = 23, the all-zero state gives lane 0 = 0xF1258F7940E1DDE7 and lane 1 = 0x84D5CCF933C0478A.
- R2: Lane (x,y) is element x+5*y of the group, and element e occupies group bits [64e+63:64e], bit 0 being the lane's least significant bit.
- R3: group_o holds the permuted lanes in elements 0 to 24, in the same layout as group_i.
- R4: When tail_agn_i = 0 at start, elements 25 to 31 of group_o equal the corresponding elements of group_i.
- R5: When tail_agn_i = 1 at start, elements 25 to 31 of group_o are all ones.
- R6: A start is accepted when busy_o is low. done_o rises exactly n+1 cycles after the accepting clock edge, for any state data, and group_o is valid in that cycle.
- R7: A start_i asserted while busy_o is high is ignored: the running result, its latency and its done pulse are unchanged, and no second done pulse follows.
- R8: err_o is high in the done cycle exactly when grp_len_lo_i or grp_off_lo_i was non-zero at start, that is when the count or the offset is not a multiple of 32. The computation still completes.
- R9: After reset, busy_o, done_o and err_o are 0 and group_o is all zeros.
- R10: done_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| rounds_i | input | 5 | Round count minus one |
| tail_agn_i | input | 1 | 1: spare elements become all ones; 0: spare elements are kept |
| grp_len_lo_i | input | 5 | Low bits of the element count, checked for alignment |
| grp_off_lo_i | input | 5 | Low bits of the starting element offset, checked for alignment |
| group_i | input | 2048 | Operand group, 32 elements of 64 bits |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | Result valid pulse |
| err_o | output | 1 | Misaligned count or offset, valid with done_o |
| group_o | output | 2048 | Result group |

## Verification
A wrong round constant, rotation amount or lane placement changes the state in a way that diffusion quickly spreads to every lane of the result. One round is enough to corrupt lane 0 and its neighbours. A miscounted sequence shows up twice at the ports: done_o arrives in the wrong cycle, and the result no longer matches a model run with the right number of rounds. A stale tail select or stale spare contents shows as soon as the done pulse comes, in elements 25 to 31, because the bench fills those elements with distinctive random data.

// File: rtl/keccak_pkg.sv
package keccak_pkg;
  localparam int LANE_W  = 64;
  localparam int NLANE   = 25;
  localparam int NELEM   = 32;
  localparam int GRP_W   = NELEM * LANE_W;
  localparam int STATE_W = NLANE * LANE_W;
  localparam int SPARE_W = GRP_W - STATE_W;
  localparam int RCNT_W  = 5;
  localparam int IDX_W   = $clog2(NELEM);
  localparam int LFSR_P  = 255;

  typedef logic [LANE_W-1:0] lane_t;
  typedef lane_t [NLANE-1:0] state_t;

  function automatic lane_t rol(lane_t v, int s);
    return (v << s) | (v >> ((LANE_W - s) % LANE_W));
  endfunction

  // one period of the iota LFSR output bit
  function automatic logic [LFSR_P-1:0] lfsr_seq();
    logic [LFSR_P-1:0] seq;
    logic [7:0] r;
    logic fb;
    seq = '0;
    r = 8'h01;
    for (int t = 0; t < LFSR_P; t++) begin
      seq[t] = r[0];
      fb = r[7];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h71;
    end
    return seq;
  endfunction

  function automatic lane_t rc_of(int idx, logic [LFSR_P-1:0] seq);
    lane_t v;
    int t;
    v = '0;
    for (int j = 0; j < 7; j++) begin
      t = (j + 7 * idx) % LFSR_P;
      if (t < 0) t = t + LFSR_P;
      v[(1 << j) - 1] = seq[t];
    end
    return v;
  endfunction

  function automatic lane_t rc_mask();
    lane_t v;
    v = '0;
    for (int j = 0; j < 7; j++) v[(1 << j) - 1] = 1'b1;
    return v;
  endfunction

  function automatic int rho_off(int e);
    int x, y, tmp, r;
    x = 1; y = 0; r = 0;
    for (int t = 0; t < 24; t++) begin
      if (x + 5 * y == e) r = ((t + 1) * (t + 2) / 2) % LANE_W;
      tmp = (2 * x + 3 * y) % 5;
      x = y;
      y = tmp;
    end
    return r;
  endfunction
endpackage

// File: rtl/keccak_rc_rom.sv
module keccak_rc_rom
  import keccak_pkg::*;
#(
  parameter int KW   = 5,
  parameter int BASE = 24 - (1 << KW)
) (
  input  logic [KW-1:0] k_i,
  output lane_t         rc_o
);
  localparam int DEPTH = 1 << KW;
  localparam logic [LFSR_P-1:0] SEQ = lfsr_seq();
  localparam lane_t MASK = rc_mask();

  lane_t tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    localparam lane_t C = rc_of(g + BASE, SEQ);
    assign tbl[g] = C;
  end

  assign rc_o = tbl[k_i];

  // R1: iota constants only touch bit positions 2^j-1
  always_comb begin
    assert_rc_sparse_R1: assert ((rc_o & ~MASK) == '0);
  end
endmodule

// File: rtl/keccak_round.sv
module keccak_round
  import keccak_pkg::*;
(
  input  state_t s_i,
  input  lane_t  rc_i,
  output state_t s_o
);
  lane_t c [5];
  lane_t d [5];
  lane_t b [NLANE];

  for (genvar gx = 0; gx < 5; gx++) begin : g_theta
    assign c[gx] = s_i[gx] ^ s_i[gx+5] ^ s_i[gx+10] ^ s_i[gx+15] ^ s_i[gx+20];
  end
  for (genvar gx = 0; gx < 5; gx++) begin : g_dcol
    assign d[gx] = c[(gx+4)%5] ^ rol(c[(gx+1)%5], 1);
  end

  for (genvar gy = 0; gy < 5; gy++) begin : g_row
    for (genvar gx = 0; gx < 5; gx++) begin : g_col
      localparam int E = gx + 5 * gy;
      localparam int P = gy + 5 * ((2 * gx + 3 * gy) % 5);
      localparam int R = rho_off(E);
      assign b[P] = rol(s_i[E] ^ d[gx], R);
      if (E == 0) begin : g_iota
        assign s_o[E] = b[E] ^ (~b[(gx+1)%5 + 5*gy] & b[(gx+2)%5 + 5*gy]) ^ rc_i;
      end else begin : g_plain
        assign s_o[E] = b[E] ^ (~b[(gx+1)%5 + 5*gy] & b[(gx+2)%5 + 5*gy]);
      end
    end
  end
endmodule

// File: rtl/keccak_rounds_unit.sv
module keccak_rounds_unit
  import keccak_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [RCNT_W-1:0]  rounds_i,
  input  logic               tail_agn_i,
  input  logic [IDX_W-1:0]   grp_len_lo_i,
  input  logic [IDX_W-1:0]   grp_off_lo_i,
  input  logic [GRP_W-1:0]   group_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [GRP_W-1:0]   group_o
);
  localparam int CNT_W = RCNT_W + 1;
  localparam logic [RCNT_W-1:0] K_TOP = {RCNT_W{1'b1}};

  state_t               st_q, st_nxt;
  logic [SPARE_W-1:0]   spare_q;
  logic                 tail_q, err_q;
  logic [CNT_W-1:0]     rem_q;
  logic [RCNT_W-1:0]    k_q;
  lane_t                rc;
  logic [CNT_W-1:0]     n_q, lat_q;

  keccak_rc_rom #(.KW(RCNT_W)) u_rc (
    .k_i  (k_q),
    .rc_o (rc)
  );

  keccak_round u_round (
    .s_i  (st_q),
    .rc_i (rc),
    .s_o  (st_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      group_o <= '0;
      st_q    <= '0;
      spare_q <= '0;
      tail_q  <= 1'b0;
      err_q   <= 1'b0;
      rem_q   <= '0;
      k_q     <= '0;
      n_q     <= '0;
      lat_q   <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          st_q    <= group_i[STATE_W-1:0];
          spare_q <= group_i[GRP_W-1:STATE_W];
          tail_q  <= tail_agn_i;
          err_q   <= (|grp_len_lo_i) | (|grp_off_lo_i);
          rem_q   <= {1'b0, rounds_i} + CNT_W'(1);
          k_q     <= K_TOP - rounds_i;
          n_q     <= {1'b0, rounds_i} + CNT_W'(1);
          lat_q   <= '0;
          busy_o  <= 1'b1;
        end
      end else begin
        lat_q <= lat_q + CNT_W'(1);
        if (rem_q != '0) begin
          st_q  <= st_nxt;
          rem_q <= rem_q - CNT_W'(1);
          k_q   <= k_q + RCNT_W'(1);
        end else begin
          group_o <= {(tail_q ? {SPARE_W{1'b1}} : spare_q), st_q};
          done_o  <= 1'b1;
          err_o   <= err_q;
          busy_o  <= 1'b0;
        end
      end
    end
  end

  // R6: done lands n+1 cycles after the accepting edge
  assert_done_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == n_q + CNT_W'(1)));

  // R10: single-cycle done
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7: a run only ends through done
  assert_busy_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  // R6: idle start is accepted
  assert_idle_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  // R8: error only alongside done
  assert_err_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

// File: tb/sim_keccak_rounds_unit.sv
`timescale 1ns/1ps
module sim_keccak_rounds_unit;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [4:0]    rounds_i = '0;
  logic          tail_agn_i = 1'b0;
  logic [4:0]    grp_len_lo_i = '0;
  logic [4:0]    grp_off_lo_i = '0;
  logic [2047:0] group_i = '0;
  logic          busy_o, done_o, err_o;
  logic [2047:0] group_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  keccak_rounds_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .rounds_i(rounds_i),
    .tail_agn_i(tail_agn_i), .grp_len_lo_i(grp_len_lo_i), .grp_off_lo_i(grp_off_lo_i),
    .group_i(group_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .group_o(group_o)
  );

  // {imm[47:43], tail[42], len[41:37], off[36:32], seed[31:0]}
  localparam logic [47:0] VEC [8] = '{
    {5'd23, 1'b0, 5'd0, 5'd0,  32'd0},
    {5'd0,  1'b0, 5'd0, 5'd0,  32'd1},
    {5'd31, 1'b1, 5'd0, 5'd0,  32'd2},
    {5'd23, 1'b1, 5'd0, 5'd0,  32'd3},
    {5'd24, 1'b0, 5'd3, 5'd0,  32'd4},
    {5'd7,  1'b0, 5'd0, 5'd16, 32'd5},
    {5'd31, 1'b0, 5'd0, 5'd0,  32'd6},
    {5'd1,  1'b1, 5'd0, 5'd0,  32'd7}
  };

  localparam int ROT [5][5] = '{
    '{0, 36, 3, 41, 18},
    '{1, 44, 10, 45, 2},
    '{62, 6, 43, 15, 61},
    '{28, 55, 25, 21, 56},
    '{27, 20, 39, 8, 14}
  };

  function automatic logic lfsr_bit(int t_in);
    logic [8:0] r;
    int t;
    t = t_in % 255;
    if (t < 0) t = t + 255;
    r = 9'd1;
    for (int i = 0; i < t; i++) begin
      r = {r[7:0], 1'b0};
      r[0] = r[0] ^ r[8];
      r[4] = r[4] ^ r[8];
      r[5] = r[5] ^ r[8];
      r[6] = r[6] ^ r[8];
    end
    return r[0];
  endfunction

  function automatic logic [63:0] rot64(logic [63:0] v, int s);
    if (s == 0) return v;
    return (v << s) | (v >> (64 - s));
  endfunction

  function automatic logic [1599:0] model(logic [1599:0] s, int n);
    logic [63:0] a [5][5];
    logic [63:0] bb [5][5];
    logic [63:0] cc [5];
    logic [63:0] dd [5];
    logic [63:0] rc;
    logic [1599:0] o;
    for (int x = 0; x < 5; x++)
      for (int y = 0; y < 5; y++) a[x][y] = s[64*(x+5*y) +: 64];
    for (int ir = 24 - n; ir < 24; ir++) begin
      for (int x = 0; x < 5; x++) cc[x] = a[x][0] ^ a[x][1] ^ a[x][2] ^ a[x][3] ^ a[x][4];
      for (int x = 0; x < 5; x++) dd[x] = cc[(x+4)%5] ^ rot64(cc[(x+1)%5], 1);
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++) bb[y][(2*x+3*y)%5] = rot64(a[x][y] ^ dd[x], ROT[x][y]);
      for (int x = 0; x < 5; x++)
        for (int y = 0; y < 5; y++) a[x][y] = bb[x][y] ^ (~bb[(x+1)%5][y] & bb[(x+2)%5][y]);
      rc = '0;
      for (int j = 0; j < 7; j++) rc[(1 << j) - 1] = lfsr_bit(j + 7 * ir);
      a[0][0] = a[0][0] ^ rc;
    end
    for (int x = 0; x < 5; x++)
      for (int y = 0; y < 5; y++) o[64*(x+5*y) +: 64] = a[x][y];
    return o;
  endfunction

  function automatic logic [2047:0] make_grp(logic [31:0] seed);
    logic [63:0] x;
    logic [2047:0] g;
    x = 64'h9E3779B97F4A7C15 ^ {32'h0, seed};
    for (int e = 0; e < 32; e++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      g[64*e +: 64] = x;
    end
    if (seed == 0) g[1599:0] = '0;
    return g;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_grp(input string req, input logic [2047:0] act, input logic [2047:0] exp,
                         input int lo, input int hi);
    int bad;
    bad = -1;
    for (int e = hi; e >= lo; e--) if (act[64*e +: 64] !== exp[64*e +: 64]) bad = e;
    if (bad < 0) chk(1'b1, req, 64'h0, 64'h0);
    else chk(1'b0, req, act[64*bad +: 64], exp[64*bad +: 64]);
  endtask

  task automatic run(input logic [4:0] imm, input logic tail, input logic [4:0] ln,
                     input logic [4:0] off, input logic [2047:0] g,
                     output int lat, output logic [2047:0] res, output logic er);
    rounds_i = imm; tail_agn_i = tail; grp_len_lo_i = ln; grp_off_lo_i = off;
    group_i = g; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    res = group_o;
    er = err_o;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int lat;
    logic [2047:0] res, g, exp_g;
    logic er;
    logic [4:0] imm;

    #1;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(busy_o === 1'b0, "R9 busy", {63'h0, busy_o}, 64'h0);
    chk(done_o === 1'b0, "R9 done", {63'h0, done_o}, 64'h0);
    chk(err_o === 1'b0, "R9 err", {63'h0, err_o}, 64'h0);
    chk_grp("R9 group_o zero", group_o, '0, 0, 31);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      imm = VEC[v][47:43];
      g = make_grp(VEC[v][31:0]);
      run(imm, VEC[v][42], VEC[v][41:37], VEC[v][36:32], g, lat, res, er);
      exp_g[1599:0] = model(g[1599:0], int'(imm) + 1);
      exp_g[2047:1600] = VEC[v][42] ? {448{1'b1}} : g[2047:1600];
      chk(lat == int'(imm) + 2, "R6 latency", 64'(lat), 64'(int'(imm) + 2));
      chk_grp("R1 R2 R3 lanes", res, exp_g, 0, 24);
      if (VEC[v][42]) chk_grp("R5 tail agnostic", res, exp_g, 25, 31);
      else chk_grp("R4 tail undisturbed", res, exp_g, 25, 31);
      chk(er === ((VEC[v][41:37] != 0) || (VEC[v][36:32] != 0)), "R8 err",
          {63'h0, er}, {63'h0, ((VEC[v][41:37] != 0) || (VEC[v][36:32] != 0))});
      if (v == 0) begin
        chk(res[63:0] === 64'hF1258F7940E1DDE7, "R1 zero lane0", res[63:0], 64'hF1258F7940E1DDE7);
        chk(res[127:64] === 64'h84D5CCF933C0478A, "R1 zero lane1", res[127:64], 64'h84D5CCF933C0478A);
      end
      @(negedge clk);
      chk(done_o === 1'b0, "R10 done pulse", {63'h0, done_o}, 64'h0);
    end

    // R7: second start during a run is ignored
    g = make_grp(32'd99);
    rounds_i = 5'd3; tail_agn_i = 1'b0; grp_len_lo_i = '0; grp_off_lo_i = '0;
    group_i = g; start_i = 1'b1;
    @(negedge clk);
    rounds_i = 5'd0; tail_agn_i = 1'b1; group_i = make_grp(32'd55);
    @(negedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 2;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    exp_g[1599:0] = model(g[1599:0], 4);
    exp_g[2047:1600] = g[2047:1600];
    chk(lat == 5, "R7 latency kept", 64'(lat), 64'd5);
    chk_grp("R7 result kept", group_o, exp_g, 0, 31);
    begin
      int extra;
      extra = 0;
      repeat (6) begin
        @(negedge clk);
        if (done_o || busy_o) extra++;
      end
      chk(extra == 0, "R7 no second run", 64'(extra), 64'd0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule